// File: doc/BRIEF.md
# Branch Condition and Next-Index Unit

This block resolves the control-transfer instructions of a 64-bit packet-filter virtual machine. Each input item carries the 8-bit opcode, the destination and source register values, the 32-bit immediate, a 16-bit signed offset and the current instruction index. The block evaluates the branch condition, decides whether the branch is taken and produces the index of the next instruction. It also raises one-cycle-per-result strobes that tell the sequencer a call or a program exit was requested, or that the encoding is not legal. Register reads, call dispatch and stack work belong to the sequencer, not to this block.

Both the input and the output are valid/ready streams. An input item is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result is shown on the output from the next cycle and stays unchanged until a rising edge with `out_valid` and `out_ready` both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. A stalled output therefore holds back the input, and no item is ever lost or duplicated.

Opcode layout: bits [2:0] give the class (5 is the 64-bit jump class, 6 is the 32-bit jump class). Bit 3 picks the second operand: 1 selects the source register, 0 selects the immediate. Bits [7:4] give the condition code: 0 unconditional, 1 equal, 2 unsigned greater, 3 unsigned greater-or-equal, 4 bit test, 5 not equal, 6 signed greater, 7 signed greater-or-equal, 8 call, 9 exit, 10 unsigned less, 11 unsigned less-or-equal, 12 signed less, 13 signed less-or-equal.

Top module: `bcu_branch_unit`

## Requirements
- R1: Class 5 compares all 64 bits of both operands. Class 6 compares only bits [31:0], so the upper halves have no effect on the outcome.
- R2: With opcode bit 3 set, the second operand is the source register. With bit 3 clear, it is the immediate sign-extended to 64 bits.
- R3: Code 1 is taken when the operands are equal, code 5 when they differ, and code 4 when their bitwise AND is nonzero.
- R4: Codes 2, 3, 10 and 11 compare the destination against the second operand as unsigned (>, >=, <, <=).
- R5: Codes 6, 7, 12 and 13 compare as two's-complement signed (>, >=, <, <=). In class 6 the sign is taken from bit 31.
- R6: A taken branch gives next index = index + 1 + sign-extended offset, modulo 2^32. Every other result gives index + 1, modulo 2^32.
- R7: Code 0 in class 5 is always taken.
- R8: Code 8 in class 5 or class 6 raises `out_call` with `out_call_id` equal to the immediate. It is not taken.
- R9: Code 9 in class 5 raises `out_exit` and is not taken.
- R10: Code 0 or 9 in class 6, codes 14 and 15, and any class other than 5 or 6 raise `out_illegal`. Such a result is not taken, raises no call or exit, and gives index + 1.
- R11: In any result, at most one of `out_taken`, `out_call`, `out_exit` and `out_illegal` is high.
- R12: `in_ready` equals NOT `out_valid` OR `out_ready`. A result appears in the cycle after its input is accepted. While `out_valid` is high and `out_ready` is low, the result and `out_valid` stay unchanged. Results leave in input order.
- R13: During reset `out_valid` is low, and right after reset `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can accept an item |
| in_opcode | input | 8 | Instruction opcode |
| in_dst | input | 64 | Destination register value |
| in_src | input | 64 | Source register value |
| in_imm | input | 32 | Immediate |
| in_off | input | 16 | Signed branch offset |
| in_pc | input | 32 | Current instruction index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 32 | Next instruction index |
| out_call | output | 1 | Call requested |
| out_call_id | output | 32 | Call target from the immediate |
| out_exit | output | 1 | Program exit requested |
| out_illegal | output | 1 | Encoding not legal |

## Verification
Two things can happen in the same cycle: the output register is drained and a new instruction is loaded into it. This is the only point where a result could be lost or doubled. The bench provokes it by keeping `in_valid` high back to back while `out_ready` follows a pseudo-random pattern, and separately by holding `out_ready` low for several cycles before releasing it. A scoreboard computes every expected result independently and pops one entry at each output handshake. A dropped, repeated or reordered result therefore appears as a mismatch or as an empty queue.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  localparam logic [2:0] CLS_JMP64 = 3'd5;
  localparam logic [2:0] CLS_JMP32 = 3'd6;

  typedef enum logic [3:0] {
    CND_ALWAYS = 4'h0,
    CND_EQ     = 4'h1,
    CND_UGT    = 4'h2,
    CND_UGE    = 4'h3,
    CND_BITS   = 4'h4,
    CND_NE     = 4'h5,
    CND_SGT    = 4'h6,
    CND_SGE    = 4'h7,
    CND_CALL   = 4'h8,
    CND_EXIT   = 4'h9,
    CND_ULT    = 4'ha,
    CND_ULE    = 4'hb,
    CND_SLT    = 4'hc,
    CND_SLE    = 4'hd,
    CND_RSV_E  = 4'he,
    CND_RSV_F  = 4'hf
  } bcu_cond_e;

  typedef enum logic [1:0] {
    KIND_BRANCH = 2'd0,
    KIND_CALL   = 2'd1,
    KIND_EXIT   = 2'd2,
    KIND_BAD    = 2'd3
  } bcu_kind_e;

endpackage

// File: rtl/bcu_operand_sel.sv
module bcu_operand_sel #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IMM_W  = 32
) (
  input  logic              use_reg,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] opnd_b
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W < DATA_W) begin : g_sext
      localparam int unsigned PAD_W = DATA_W - IMM_W;
      assign imm_ext = {{PAD_W{imm_val[IMM_W-1]}}, imm_val};
    end else begin : g_trunc
      assign imm_ext = imm_val[DATA_W-1:0];
    end
  endgenerate

  assign opnd_b = use_reg ? src_val : imm_ext;
endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  bcu_cond_e         cond,
  input  logic              narrow,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              hit
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] ua, ub, sa, sb;
  logic eq, ult, slt, any_bit;

  always_comb begin
    if (narrow) begin
      ua = {{HALF_W{1'b0}}, opnd_a[HALF_W-1:0]};
      ub = {{HALF_W{1'b0}}, opnd_b[HALF_W-1:0]};
      sa = {{HALF_W{opnd_a[HALF_W-1]}}, opnd_a[HALF_W-1:0]};
      sb = {{HALF_W{opnd_b[HALF_W-1]}}, opnd_b[HALF_W-1:0]};
    end else begin
      ua = opnd_a;
      ub = opnd_b;
      sa = opnd_a;
      sb = opnd_b;
    end
  end

  assign eq      = (ua == ub);
  assign ult     = (ua < ub);
  assign slt     = ($signed(sa) < $signed(sb));
  assign any_bit = |(ua & ub);

  always_comb begin
    case (cond)
      CND_ALWAYS: hit = 1'b1;
      CND_EQ:     hit = eq;
      CND_NE:     hit = !eq;
      CND_BITS:   hit = any_bit;
      CND_UGT:    hit = !ult && !eq;
      CND_UGE:    hit = !ult;
      CND_ULT:    hit = ult;
      CND_ULE:    hit = ult || eq;
      CND_SGT:    hit = !slt && !eq;
      CND_SGE:    hit = !slt;
      CND_SLT:    hit = slt;
      CND_SLE:    hit = slt || eq;
      default:    hit = 1'b0;
    endcase
  end

  // unsigned less-than and equality come from separate comparators (R4)
  always_comb begin
    if (ult === 1'b1) begin
      p_ult_not_eq_r4: assert (eq !== 1'b1);
    end
  end

  // signed less-than and equality come from separate comparators (R5)
  always_comb begin
    if (slt === 1'b1) begin
      p_slt_not_eq_r5: assert (eq !== 1'b1);
    end
  end
endmodule

// File: rtl/bcu_next_pc.sv
module bcu_next_pc #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic             take,
  output logic [PC_W-1:0]  next_pc
);
  logic [PC_W-1:0] off_ext, seq_pc, tgt_pc;

  generate
    if (OFF_W < PC_W) begin : g_sext
      localparam int unsigned PAD_W = PC_W - OFF_W;
      assign off_ext = {{PAD_W{off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[PC_W-1:0];
    end
  endgenerate

  assign seq_pc  = pc + PC_W'(1);
  assign tgt_pc  = seq_pc + off_ext;
  assign next_pc = take ? tgt_pc : seq_pc;
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
  import bcu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IMM_W  = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [OFF_W-1:0]  in_off,
  input  logic [PC_W-1:0]   in_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_call,
  output logic [IMM_W-1:0]  out_call_id,
  output logic              out_exit,
  output logic              out_illegal
);
  logic [2:0]        cls;
  bcu_cond_e         cond;
  logic              use_reg, is_wide, is_narrow;
  bcu_kind_e         kind;
  logic [DATA_W-1:0] opnd_b;
  logic              hit, taken_c, accept;
  logic [PC_W-1:0]   next_c;

  assign cls       = in_opcode[2:0];
  assign cond      = bcu_cond_e'(in_opcode[7:4]);
  assign use_reg   = in_opcode[3];
  assign is_wide   = (cls == CLS_JMP64);
  assign is_narrow = (cls == CLS_JMP32);

  always_comb begin
    if (!(is_wide || is_narrow)) begin
      kind = KIND_BAD;
    end else begin
      case (cond)
        CND_CALL:             kind = KIND_CALL;
        CND_EXIT:             kind = is_wide ? KIND_EXIT : KIND_BAD;
        CND_ALWAYS:           kind = is_wide ? KIND_BRANCH : KIND_BAD;
        CND_RSV_E, CND_RSV_F: kind = KIND_BAD;
        default:              kind = KIND_BRANCH;
      endcase
    end
  end

  bcu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .use_reg (use_reg),
    .src_val (in_src),
    .imm_val (in_imm),
    .opnd_b  (opnd_b)
  );

  bcu_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .cond   (cond),
    .narrow (is_narrow),
    .opnd_a (in_dst),
    .opnd_b (opnd_b),
    .hit    (hit)
  );

  assign taken_c = (kind == KIND_BRANCH) && hit;

  bcu_next_pc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_npc (
    .pc      (in_pc),
    .off     (in_off),
    .take    (taken_c),
    .next_pc (next_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_next_pc <= '0;
      out_call    <= 1'b0;
      out_call_id <= '0;
      out_exit    <= 1'b0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken   <= taken_c;
        out_next_pc <= next_c;
        out_call    <= (kind == KIND_CALL);
        out_call_id <= (kind == KIND_CALL) ? in_imm : '0;
        out_exit    <= (kind == KIND_EXIT);
        out_illegal <= (kind == KIND_BAD);
      end
    end
  end

  p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_taken, out_call, out_exit, out_illegal}));

  p_hold_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc) &&
      $stable(out_taken) && $stable(out_call) && $stable(out_exit) && $stable(out_illegal)));

  p_seq_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !taken_c) |=> (out_next_pc == ($past(in_pc) + PC_W'(1))));

  p_narrow_bad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_narrow && (in_opcode[7:4] == 4'h0 || in_opcode[7:4] == 4'h9))
      |=> (out_illegal && !out_taken && !out_exit));

  p_call_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (is_wide || is_narrow) && in_opcode[7:4] == 4'h8)
      |=> (out_call && out_call_id == $past(in_imm)));

  p_exit_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_wide && in_opcode[7:4] == 4'h9) |=> (out_exit && !out_taken));

  p_reset_empty_r13: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

// File: tb/bcu_branch_unit_tb.sv
`timescale 1ns/1ps
module bcu_branch_unit_tb;
  localparam time HALF = 10ns;

  typedef struct packed {
    logic        taken;
    logic [31:0] next;
    logic        call;
    logic [31:0] id;
    logic        exit;
    logic        ill;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [63:0] in_dst = '0, in_src = '0;
  logic [31:0] in_imm = '0;
  logic [15:0] in_off = '0;
  logic [31:0] in_pc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken, out_call, out_exit, out_illegal;
  logic [31:0] out_next_pc, out_call_id;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t exp_q[$];
  string tag_q[$];
  bit   ready_rand = 1'b0;
  bit   ready_force = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  always #HALF clk = ~clk;

  bcu_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
    .in_off(in_off), .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_next_pc(out_next_pc), .out_call(out_call),
    .out_call_id(out_call_id), .out_exit(out_exit), .out_illegal(out_illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                                 input logic [31:0] im, input logic [15:0] of, input logic [31:0] pc);
    exp_t e;
    logic [63:0] b, ua, ub;
    longint sa, sb;
    bit narrow, hit;
    e = '0;
    hit = 0;
    b = op[3] ? s : {{32{im[31]}}, im};
    narrow = (op[2:0] == 3'd6);
    ua = narrow ? {32'h0, d[31:0]} : d;
    ub = narrow ? {32'h0, b[31:0]} : b;
    sa = narrow ? longint'($signed(d[31:0])) : longint'($signed(d));
    sb = narrow ? longint'($signed(b[31:0])) : longint'($signed(b));
    e.next = pc + 32'd1;
    if (op[2:0] != 3'd5 && !narrow) e.ill = 1;
    else begin
      case (op[7:4])
        4'h8: begin e.call = 1; e.id = im; end
        4'h9: if (narrow) e.ill = 1; else e.exit = 1;
        4'h0: if (narrow) e.ill = 1; else hit = 1;
        4'he, 4'hf: e.ill = 1;
        4'h1: hit = (ua == ub);
        4'h5: hit = (ua != ub);
        4'h4: hit = ((ua & ub) != 0);
        4'h2: hit = (ua > ub);
        4'h3: hit = (ua >= ub);
        4'ha: hit = (ua < ub);
        4'hb: hit = (ua <= ub);
        4'h6: hit = (sa > sb);
        4'h7: hit = (sa >= sb);
        4'hc: hit = (sa < sb);
        default: hit = (sa <= sb);
      endcase
    end
    if (hit) begin
      e.taken = 1;
      e.next = pc + 32'd1 + {{16{of[15]}}, of};
    end
    return e;
  endfunction

  task automatic send(input string req, input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                      input logic [31:0] im, input logic [15:0] of, input logic [31:0] pc);
    @(negedge clk); #2;
    in_valid = 1'b1; in_opcode = op; in_dst = d; in_src = s;
    in_imm = im; in_off = of; in_pc = pc;
    while (!in_ready) begin @(negedge clk); #2; end
    exp_q.push_back(model(op, d, s, im, of, pc));
    tag_q.push_back(req);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk); #2;
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= ready_rand ? (lfsr[0] | lfsr[3]) : ready_force;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e, a;
    string t;
    #2;
    if (rst_n && out_valid && out_ready) begin
      a = '{out_taken, out_next_pc, out_call, out_call_id, out_exit, out_illegal};
      if (exp_q.size() == 0) begin
        chk(0, "R12 unexpected result", {1'b0, a}, '0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a == e, t, {1'b0, a}, {1'b0, e});
        chk($countones({out_taken, out_call, out_exit, out_illegal}) <= 1, "R11",
            {124'b0, out_taken, out_call, out_exit, out_illegal}, 0);
      end
    end
  end

  task automatic run_vectors();
    // R1: width by class
    send("R1 wide eq upper differs", 8'h1D, 64'h1_0000_0005, 64'h2_0000_0005, 0, 16'd7, 32'd100);
    send("R1 narrow eq upper ignored", 8'h1E, 64'h1_0000_0005, 64'h2_0000_0005, 0, 16'd7, 32'd100);
    send("R1 narrow ugt upper ignored", 8'h2E, 64'h0_0000_0001, 64'hF_0000_0000, 0, 16'd3, 32'd5);
    // R2: operand selection and immediate extension
    send("R2 imm sext all ones", 8'h15, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd4, 32'd20);
    send("R2 imm sext mismatch", 8'h15, 64'h0000_0000_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd4, 32'd20);
    send("R2 reg chosen over imm", 8'h1D, 64'd9, 64'd9, 32'd3, 16'd2, 32'd30);
    send("R2 imm chosen over reg", 8'h15, 64'd9, 64'd9, 32'd3, 16'd2, 32'd30);
    // R3: eq / ne / bit test
    send("R3 ne taken", 8'h5D, 64'd1, 64'd2, 0, 16'd10, 32'd40);
    send("R3 ne not taken", 8'h5D, 64'd2, 64'd2, 0, 16'd10, 32'd40);
    send("R3 bittest hit", 8'h4D, 64'h8000_0000_0000_0010, 64'h10, 0, 16'd1, 32'd50);
    send("R3 bittest miss", 8'h4D, 64'hF0, 64'h0F, 0, 16'd1, 32'd50);
    // R4: unsigned
    send("R4 ugt big", 8'h2D, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 16'd6, 32'd60);
    send("R4 uge equal", 8'h3D, 64'd77, 64'd77, 0, 16'd6, 32'd60);
    send("R4 ult", 8'hAD, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 16'd6, 32'd60);
    send("R4 ule greater", 8'hBD, 64'd8, 64'd7, 0, 16'd6, 32'd60);
    // R5: signed
    send("R5 sgt neg", 8'h6D, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 16'd2, 32'd70);
    send("R5 slt neg", 8'hCD, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 16'd2, 32'd70);
    send("R5 sge equal", 8'h7D, 64'd5, 64'd5, 0, 16'd2, 32'd70);
    send("R5 sle", 8'hDD, 64'd6, 64'd5, 0, 16'd2, 32'd70);
    send("R5 narrow sign bit31", 8'hCE, 64'h0000_0000_8000_0000, 64'd0, 0, 16'd2, 32'd70);
    send("R5 wide bit31 positive", 8'hCD, 64'h0000_0000_8000_0000, 64'd0, 0, 16'd2, 32'd70);
    // R6: index arithmetic
    send("R6 negative offset", 8'h1D, 64'd3, 64'd3, 0, 16'hFFFB, 32'd10);
    send("R6 wrap sequential", 8'h1D, 64'd3, 64'd4, 0, 16'd9, 32'hFFFF_FFFF);
    // R7 .. R10
    send("R7 always", 8'h05, 64'd0, 64'd0, 0, 16'd100, 32'd200);
    send("R8 call wide", 8'h85, 0, 0, 32'h0000_1234, 16'd0, 32'd300);
    send("R8 call narrow", 8'h86, 0, 0, 32'hDEAD_0001, 16'd5, 32'd301);
    send("R9 exit wide", 8'h95, 0, 0, 0, 16'd5, 32'd400);
    send("R10 always narrow", 8'h06, 0, 0, 0, 16'd5, 32'd500);
    send("R10 exit narrow", 8'h96, 0, 0, 0, 16'd5, 32'd501);
    send("R10 reserved code", 8'hED, 64'd1, 64'd1, 0, 16'd5, 32'd502);
    send("R10 non jump class", 8'h1C, 64'd1, 64'd1, 0, 16'd5, 32'd503);
  endtask

  task automatic drain();
    int spin = 0;
    idle();
    while ((exp_q.size() != 0 || out_valid) && spin < 1000) begin
      @(negedge clk); #3; spin++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held_pc;
    logic        held_taken;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R13 valid in reset", {127'b0, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(out_valid == 1'b0, "R13 valid after reset", {127'b0, out_valid}, 0);
    chk(in_ready == 1'b1, "R13 ready after reset", {127'b0, in_ready}, 1);

    // phase 1: consumer always ready, back to back
    run_vectors();
    drain();

    // phase 2: explicit stall R12
    ready_force = 1'b0;
    @(negedge clk);
    send("R12 released after stall", 8'h1D, 64'd1, 64'd1, 0, 16'd20, 32'd900);
    idle();
    #1;
    held_pc = out_next_pc;
    held_taken = out_taken;
    chk(out_valid == 1'b1, "R12 result one cycle after accept", {127'b0, out_valid}, 1);
    chk(held_pc == 32'd921, "R12 stalled index", {96'b0, held_pc}, 921);
    repeat (3) @(negedge clk);
    #3;
    chk(out_valid == 1'b1 && out_next_pc == held_pc && out_taken == held_taken,
        "R12 held under stall", {95'b0, out_valid, out_next_pc}, {95'b0, 1'b1, held_pc});
    chk(in_ready == 1'b0, "R12 ready low while full", {127'b0, in_ready}, 0);
    ready_force = 1'b1;
    drain();

    // phase 3: random back-pressure with simultaneous drain and load
    ready_rand = 1'b1;
    run_vectors();
    drain();
    ready_rand = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R12 all results delivered", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule